// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from the moment power and clock are stable to the point where it may accept normal traffic. A one-cycle `start` pulse launches a fixed schedule on the command pins. Clock enable goes high first, and a long settling wait follows. The sequencer then issues a precharge of all banks and a run of auto-refresh commands. It ends by writing the mode register with a fixed configuration word. Each command is separated from the next by the device's minimum spacing, and every other cycle carries a no-operation.

Once the mode-register write has had time to settle, `init_done` rises and stays high. A periodic refresh timer then starts. Its reload value is derived from a 15.62 µs refresh interval at the SDRAM clock rate, less a fixed margin of 20 cycles. Each time the timer expires, `refresh_req` pulses for one cycle so that a downstream controller can schedule an auto-refresh. Reads, writes and the data bus are handled elsewhere.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is high and afterwards until `start` is seen, `cke` is 0, the command pins show deselect (`{cs_n,ras_n,cas_n,we_n}` = 4'b1111), `addr` and `ba` are 0, and `init_done` and `refresh_req` are 0.
- R2: When `start` is sampled high at a clock edge in the idle state, `cke` is 1 from the following cycle onward, and the next STABLE_CYCLES cycles carry NOP only.
- R3: The cycle right after the settling wait carries precharge-all (`{cs_n,ras_n,cas_n,we_n}` = 4'b0010) with `addr[10]` = 1 and all other address bits 0. The next command comes T_RP (2) cycles later.
- R4: AR_COUNT (8) auto-refresh commands (4'b0001) follow. The first comes T_RP cycles after precharge-all, and each of the others comes T_RC (6) cycles after the one before it.
- R5: T_RC cycles after the last auto-refresh, a mode-register load (4'b0000) is issued with `ba` = 0 and `addr` = 13'h230. That word means burst length 1 (A[2:0]=000), sequential order (A3=0), CAS latency 3 (A[6:4]=011), standard mode (A[8:7]=00) and single-location write burst (A9=1).
- R6: `init_done` is 0 until T_MRD (2) cycles after the mode-register load cycle. From that cycle on it stays 1 until reset.
- R7: While `cke` is 1, every cycle that does not carry one of the commands above carries NOP (4'b0111) with `addr` and `ba` at 0.
- R8: RELOAD = floor(REFRESH_NS × CLK_KHZ / 10^6) − REFRESH_MARGIN. The first one-cycle `refresh_req` pulse comes RELOAD cycles after the first `init_done` cycle, and each later pulse comes RELOAD+1 cycles after the previous one. `refresh_req` is never high while `init_done` is 0.
- R9: A `start` pulse during the sequence or after `init_done` has no effect: the command schedule, `init_done` and the refresh pulse spacing are unchanged.
- R10: Reset in the middle of the sequence returns the block to the R1 state. A later `start` runs the full schedule again from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SDRAM-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin initialization |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete, sticky until reset |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
The checker tests, on every cycle, the rules that hold locally. Deselect is shown whenever clock enable is low, and clock enable never drops once raised. Precharge-all always carries A10 and is followed by a NOP. Every mode-register load carries the fixed word with bank 0. The done flag is sticky, and refresh pulses last one cycle and occur only once the block is done. The exact placement of each command, the count of eight refreshes, the settling length, the refresh period and the immunity to stray start pulses and mid-sequence reset depend on absolute cycle positions, so the bench's scenarios check those against a schedule it computes from the parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PRE,
        ST_AREF,
        ST_LMR,
        ST_GAP,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_DESEL = 4'b1111;
    localparam sd_cmd_t CMD_NOP   = 4'b0111;
    localparam sd_cmd_t CMD_PRE   = 4'b0010;
    localparam sd_cmd_t CMD_AREF  = 4'b0001;
    localparam sd_cmd_t CMD_LMR   = 4'b0000;

    localparam int PRE_ALL_BIT = 10;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // burst len 1, sequential, CAS latency, standard mode, single write burst
    function automatic logic [12:0] mode_word(input int cas_lat);
        logic [2:0] cl;
        cl = 3'(cas_lat);
        return {3'b000, 1'b1, 2'b00, cl, 1'b0, 3'b000};
    endfunction

    function automatic int refresh_reload(input int ns, input int khz, input int margin);
        longint cyc;
        cyc = (longint'(ns) * longint'(khz)) / 64'sd1000000;
        return int'(cyc) - margin;
    endfunction

endpackage

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int STABLE_CYCLES = 9_000_000,
    parameter int AR_COUNT      = 8,
    parameter int T_RP          = 2,
    parameter int T_RC          = 6,
    parameter int T_MRD         = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output seq_state_e state
);
    localparam int MAXW = max2(max2(STABLE_CYCLES, T_RP), max2(T_RC, T_MRD));
    localparam int CW   = $clog2(MAXW + 1);
    localparam int ARW  = $clog2(AR_COUNT + 1);

    logic [CW-1:0]  cnt;
    logic [ARW-1:0] ar_done;
    seq_state_e     ret_state;

    logic       issuing;
    int         gap_len;
    seq_state_e target;

    always_comb begin
        issuing = 1'b0;
        gap_len = 1;
        target  = ST_READY;
        unique case (state)
            ST_PRE: begin
                issuing = 1'b1;
                gap_len = T_RP;
                target  = ST_AREF;
            end
            ST_AREF: begin
                issuing = 1'b1;
                gap_len = T_RC;
                target  = (ar_done == ARW'(AR_COUNT - 1)) ? ST_LMR : ST_AREF;
            end
            ST_LMR: begin
                issuing = 1'b1;
                gap_len = T_MRD;
                target  = ST_READY;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ret_state <= ST_IDLE;
            cnt       <= '0;
            ar_done   <= '0;
        end else begin
            if (state == ST_AREF) ar_done <= ar_done + 1'b1;
            if (issuing) begin
                if (gap_len <= 1) begin
                    state <= target;
                end else begin
                    state     <= ST_GAP;
                    ret_state <= target;
                    cnt       <= CW'(gap_len - 2);
                end
            end else begin
                unique case (state)
                    ST_IDLE: if (start) begin
                        state   <= ST_SETTLE;
                        cnt     <= CW'(STABLE_CYCLES - 1);
                        ar_done <= '0;
                    end
                    ST_SETTLE, ST_GAP: begin
                        if (cnt == '0) state <= (state == ST_SETTLE) ? ST_PRE : ret_state;
                        else           cnt   <= cnt - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int CAS_LAT = 3
) (
    input  seq_state_e        state,
    output logic              cke,
    output sd_cmd_t           cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] MODE_VAL = ADDR_W'(mode_word(CAS_LAT));
    localparam logic [ADDR_W-1:0] PRE_VAL  = ADDR_W'(1) << PRE_ALL_BIT;

    always_comb begin
        cke  = (state != ST_IDLE);
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_IDLE: cmd = CMD_DESEL;
            ST_PRE: begin
                cmd  = CMD_PRE;
                addr = PRE_VAL;
            end
            ST_AREF: cmd = CMD_AREF;
            ST_LMR: begin
                cmd  = CMD_LMR;
                addr = MODE_VAL;
            end
            default: cmd = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int RELOAD = 1385
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic req
);
    localparam int RW = $clog2(RELOAD + 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable)    cnt <= RW'(RELOAD);
        else if (cnt == '0)    cnt <= RW'(RELOAD);
        else                   cnt <= cnt - 1'b1;
    end

    assign req = enable && (cnt == '0);
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W         = 13,
    parameter int BA_W           = 2,
    parameter int STABLE_CYCLES  = 9_000_000,
    parameter int AR_COUNT       = 8,
    parameter int T_RP           = 2,
    parameter int T_RC           = 6,
    parameter int T_MRD          = 2,
    parameter int CAS_LAT        = 3,
    parameter int CLK_KHZ        = 90_000,
    parameter int REFRESH_NS     = 15_620,
    parameter int REFRESH_MARGIN = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              refresh_req
);
    localparam int RELOAD = refresh_reload(REFRESH_NS, CLK_KHZ, REFRESH_MARGIN);

    seq_state_e state;
    sd_cmd_t    cmd;

    sdram_init_fsm #(
        .STABLE_CYCLES(STABLE_CYCLES),
        .AR_COUNT     (AR_COUNT),
        .T_RP         (T_RP),
        .T_RC         (T_RC),
        .T_MRD        (T_MRD)
    ) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .state(state)
    );

    sdram_cmd_encode #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .CAS_LAT(CAS_LAT)
    ) u_enc (
        .state(state),
        .cke  (cke),
        .cmd  (cmd),
        .ba   (ba),
        .addr (addr)
    );

    assign init_done = (state == ST_READY);

    sdram_refresh_timer #(
        .RELOAD(RELOAD)
    ) u_refresh (
        .clk   (clk),
        .rst   (rst),
        .enable(init_done),
        .req   (refresh_req)
    );

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int T_RP    = 2,
    parameter int CAS_LAT = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done,
    input logic              refresh_req
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    localparam logic [ADDR_W-1:0] MODE_EXP = ADDR_W'(sdram_init_pkg::mode_word(CAS_LAT));

    // R1: clock enable low means the device is deselected
    a_r1_desel_when_cke_low: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (pins == 4'b1111));

    // R2: clock enable never drops once raised
    a_r2_cke_holds: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R3: precharge-all carries A10
    a_r3_pre_a10: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010) |-> addr[10]);

    // R3: spacing after precharge is filled with NOP
    a_r3_pre_gap: assert property (@(posedge clk) disable iff (rst)
        ((pins == 4'b0010) && (T_RP > 1)) |=> (pins == 4'b0111));

    // R5: mode load carries the fixed word on bank 0
    a_r5_mode_word: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000) |-> ((addr == MODE_EXP) && (ba == '0)));

    // R6: done is sticky
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R8: refresh strobe only once done, and one cycle wide
    a_r8_req_after_done: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> init_done);

    a_r8_req_single: assert property (@(posedge clk) disable iff (rst)
        refresh_req |=> !refresh_req);

    // R7: after done, only NOP on the pins
    a_r7_nop_when_done: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (pins == 4'b0111));
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .T_RP   (T_RP),
    .CAS_LAT(CAS_LAT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr       (addr),
    .init_done  (init_done),
    .refresh_req(refresh_req)
);

// File: tb/sdram_powerup_seq_bench.sv
`timescale 1ns/1ps
module sdram_powerup_seq_bench;
    localparam int S       = 20;
    localparam int NAR     = 8;
    localparam int TRP     = 2;
    localparam int TRC     = 6;
    localparam int TMRD    = 2;
    localparam int KHZ     = 50_000;
    localparam int RNS     = 1_000;
    localparam int MARGIN  = 20;
    localparam int RELOAD  = (RNS * KHZ) / 1_000_000 - MARGIN;
    localparam int P_PRE   = S;
    localparam int P_AR0   = S + TRP;
    localparam int P_LMR   = P_AR0 + (NAR - 1) * TRC + TRC;
    localparam int P_DONE  = P_LMR + TMRD;
    localparam int RUN_LEN = P_DONE + RELOAD + 3 * (RELOAD + 1) + 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        init_done, refresh_req;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sdram_powerup_seq #(
        .STABLE_CYCLES (S),
        .AR_COUNT      (NAR),
        .T_RP          (TRP),
        .T_RC          (TRC),
        .T_MRD         (TMRD),
        .CLK_KHZ       (KHZ),
        .REFRESH_NS    (RNS),
        .REFRESH_MARGIN(MARGIN)
    ) u_sdram_powerup_seq (
        .clk(clk), .rst(rst), .start(start),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done), .refresh_req(refresh_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_pins(input int p);
        if (p == P_PRE) return 4'b0010;
        if (p == P_LMR) return 4'b0000;
        if (p >= P_AR0 && p < P_LMR && ((p - P_AR0) % TRC) == 0) return 4'b0001;
        return 4'b0111;
    endfunction

    function automatic logic [12:0] exp_addr(input int p);
        if (p == P_PRE) return 13'h400;
        if (p == P_LMR) return 13'h230;
        return 13'h000;
    endfunction

    function automatic logic exp_req(input int p);
        int q;
        q = p - P_DONE;
        if (q < RELOAD) return 1'b0;
        return ((q - RELOAD) % (RELOAD + 1)) == 0;
    endfunction

    function automatic string tag_of(input int p);
        if (p == P_PRE) return "R3";
        if (p == P_LMR) return "R5";
        if (exp_pins(p) == 4'b0001) return "R4";
        if (p < S) return "R2";
        return "R7";
    endfunction

    task automatic idle_check(input string req);
        check(req, {27'd0, cke, cs_n, ras_n, cas_n, we_n}, 32'h0F);
        check(req, {17'd0, ba, addr}, 32'h0);
        check(req, {30'd0, init_done, refresh_req}, 32'h0);
    endtask

    // drives start, then checks the schedule period by period;
    // stray_a/stray_b are periods in which an extra start is driven (R9)
    task automatic run_schedule(input int stray_a, input int stray_b, input int stray_c, input string note);
        @(negedge clk);
        start = 1'b1;
        for (int p = 0; p < RUN_LEN; p++) begin
            @(negedge clk);
            start = (p == stray_a || p == stray_b || p == stray_c);
            check(tag_of(p), {31'd0, cke}, 32'd1);
            check(tag_of(p), {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, exp_pins(p)});
            check(tag_of(p), {17'd0, ba, addr}, {19'd0, exp_addr(p)});
            check((p >= P_DONE) ? {"R6 ", note} : "R6", {31'd0, init_done}, {31'd0, (p >= P_DONE)});
            check({"R8 ", note}, {31'd0, refresh_req}, {31'd0, exp_req(p)});
        end
        start = 1'b0;
    endtask

    task automatic t_reset_state;
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        idle_check("R1 in reset");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        idle_check("R1 idle without start");
    endtask

    task automatic t_full_sequence;
        run_schedule(-1, -1, -1, "plain");
    endtask

    task automatic t_stray_starts;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // during settle, during refresh burst, after done
        run_schedule(S / 2, P_AR0 + 3, P_DONE + 5, "R9 stray start");
    endtask

    task automatic t_mid_reset;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (P_AR0 + 10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        idle_check("R10 reset mid-sequence");
        rst = 1'b0;
        repeat (4) @(negedge clk);
        idle_check("R10 idle after reset");
        run_schedule(-1, -1, -1, "R10 rerun");
    endtask

    initial begin
        rst = 1'b1;
        start = 1'b0;
        t_reset_state();
        t_full_sequence();
        t_stray_starts();
        t_mid_reset();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20_000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule